// File: doc/BRIEF.md
# Forwarding Decision Policy Resolver

This block turns the outcome of a frame's address lookup into the egress decision that the switching core acts on. For every frame it is handed the class of the fast-forward hit (if any), the frame priority, the fast-path port mask and the per-port learning enable. It then chooses between the fast-path result and the later full-lookup response, which carries a port mask and an unrecognized-destination flag. A small set of policy inputs shapes the choice. A priority mask marks which priorities count as high priority. Two enables decide whether high-priority and unrecognized flood traffic may reach the CPU port. One bit selects drop or flood when the full lookup falls behind. Two debug bits pin the choice to one lookup path. The CPU port is a build-time mask.

Each frame is held in a one-deep pending slot. A frame that the fast path can settle is decided on the clock edge after it is accepted. A frame that needs the full lookup stays pending until the response arrives. If the next frame arrives first, the pending frame is given a fallback decision. Every decision appears as a registered port mask with drop, high-priority and learning flags, qualified by a one-cycle valid strobe. The block also turns the occupancy count of the external unrecognized-request queue into a registered level interrupt.

Top module: `fwd_policy_resolver`

## Requirements
- R1: While reset is low, and in every cycle without a decision, the outputs dec_valid, dec_mask, dec_drop, dec_hp and dec_learn are all zero.
- R2: With neither debug bit set, a frame whose req_class is not NONE is decided on the fast path. The decision is registered on the edge after the edge at which req_valid was sampled. The class encodes as NONE=0, BCAST=1 (all ports), UCAST=2 (req_fast_mask) and LLOCAL=3 (exactly the CPU mask).
- R3: A fast-path decision sets dec_hp exactly when bit req_prio of cfg_prio_mask is 1. Decisions taken from the full lookup or from a fallback never set dec_hp.
- R4: A high-priority fast-path decision of class BCAST or UCAST has the CPU port bits cleared unless cfg_hp_cpu_en is 1. LLOCAL decisions always keep the CPU port.
- R5: A frame with req_class NONE waits in the pending slot. It is decided on the edge at which full_valid is sampled high with full_unrec low, and the resulting dec_mask equals full_mask. A full_valid with no frame waiting for it has no effect.
- R6: A full response with full_unrec high yields a flood to all ports. The CPU port is removed unless cfg_unrec_cpu_en is 1.
- R7: dec_learn is set with a decision exactly when that decision came from a full response with full_unrec high, and both cfg_learn_dst_en and the frame's req_port_learn are 1.
- R8: If req_valid is sampled while a frame is still waiting for its full response, and full_valid is low in that cycle, the waiting frame is decided at once. The decision is dropped when cfg_slow_bcast is 0 and flooded to all non-CPU ports when it is 1. The new frame then takes the pending slot.
- R9: dec_drop is 1 in a decision exactly when its dec_mask is all zero.
- R10: With cfg_force_fast set and cfg_force_full clear, every frame is decided on the fast path, even with class NONE. In that case the frame is dropped.
- R11: With cfg_force_full set, every frame waits for the full response, whatever its class and whatever the value of cfg_force_fast.
- R12: uq_irq is 1 in the cycle after uq_level is sampled non-zero and 0 in the cycle after it is sampled zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_prio_mask | input | 2**PRIO_W | High-priority classification mask, bit n for priority n |
| cfg_hp_cpu_en | input | 1 | Let high-priority fast-path frames reach the CPU port |
| cfg_unrec_cpu_en | input | 1 | Let unrecognized-destination floods reach the CPU port |
| cfg_slow_bcast | input | 1 | Fallback when full lookup is late: 0 drop, 1 flood |
| cfg_learn_dst_en | input | 1 | Allow learning requests for unknown destinations |
| cfg_force_fast | input | 1 | Debug: decide every frame on the fast path |
| cfg_force_full | input | 1 | Debug: decide every frame on the full lookup (wins over force_fast) |
| req_valid | input | 1 | A new frame's lookup information is presented |
| req_class | input | 2 | Fast-forward hit class (NONE, BCAST, UCAST, LLOCAL) |
| req_prio | input | PRIO_W | Frame priority |
| req_fast_mask | input | NPORTS | Port mask from a unicast fast-forward hit |
| req_port_learn | input | 1 | Learning enabled on the ingress port |
| full_valid | input | 1 | Full-lookup response strobe |
| full_mask | input | NPORTS | Port mask from the full lookup |
| full_unrec | input | 1 | Full lookup did not recognize the destination |
| uq_level | input | LVL_W | Occupancy of the unrecognized-request queue |
| dec_valid | output | 1 | Decision strobe, one cycle per frame |
| dec_mask | output | NPORTS | Final egress port mask |
| dec_drop | output | 1 | Frame is dropped |
| dec_hp | output | 1 | Frame classified high priority |
| dec_learn | output | 1 | Push a request to the unrecognized-request queue |
| uq_irq | output | 1 | Unrecognized-request queue not empty |

## Verification
A corrupted pending slot shows up at the ports within one decision. A lost valid bit makes a fast-path frame vanish, or makes a late full response go unanswered. A stuck valid bit produces an extra dec_valid strobe or a spurious fallback on the next arrival. Wrong stored class, priority or learn fields appear as a wrong mask or flag on the very strobe that belongs to that frame. A wrong path-select state changes the cycle of dec_valid by at least one clock. The reference model is compared on every clock, so these faults are seen in the cycle they first touch an output.

// File: rtl/fpr_pkg.sv
// Shared types for the forwarding decision policy resolver.
// Assumes a two-bit fast-forward class code, fixed by the block's interface.
package fpr_pkg;

    typedef enum logic [1:0] {
        FF_NONE   = 2'd0,
        FF_BCAST  = 2'd1,
        FF_UCAST  = 2'd2,
        FF_LLOCAL = 2'd3
    } ff_class_t;

endpackage

// File: rtl/fpr_fast_path.sv
// Fast-path result: builds the port mask for a fast-forward hit and
// classifies it as high priority from the priority mask. High-priority
// broadcast/unicast hits lose the CPU port unless allowed; link-local
// hits always go to the CPU. Purely combinational.
module fpr_fast_path
    import fpr_pkg::*;
#(
    parameter int unsigned NPORTS = 8,
    parameter int unsigned PRIO_W = 3,
    parameter logic [NPORTS-1:0] CPU_MASK = 8'h01,
    localparam int unsigned NPRIO = 1 << PRIO_W
) (
    input  ff_class_t          cls,
    input  logic [PRIO_W-1:0]  prio,
    input  logic [NPORTS-1:0]  ucast_mask,
    input  logic [NPRIO-1:0]   prio_mask,
    input  logic               hp_cpu_en,
    output logic               hit,
    output logic               hp,
    output logic [NPORTS-1:0]  mask
);

    logic [NPORTS-1:0] raw_mask;

    // Select the raw mask for the hit class.
    always_comb begin
        unique case (cls)
            FF_BCAST:  raw_mask = '1;
            FF_UCAST:  raw_mask = ucast_mask;
            FF_LLOCAL: raw_mask = CPU_MASK;
            default:   raw_mask = '0;
        endcase
    end

    assign hit = (cls != FF_NONE);
    assign hp  = hit && prio_mask[prio];

    // Apply the CPU suppression rule for high-priority traffic.
    always_comb begin
        if (hp && !hp_cpu_en && (cls != FF_LLOCAL))
            mask = raw_mask & ~CPU_MASK;
        else
            mask = raw_mask;
    end

endmodule

// File: rtl/fpr_full_path.sv
// Full-lookup result: passes a recognized mask through, or floods an
// unrecognized destination (CPU removed unless allowed) and raises a
// learning request when both learning enables are set. Combinational.
module fpr_full_path #(
    parameter int unsigned NPORTS = 8,
    parameter logic [NPORTS-1:0] CPU_MASK = 8'h01
) (
    input  logic [NPORTS-1:0] lookup_mask,
    input  logic              unrec,
    input  logic              unrec_cpu_en,
    input  logic              learn_dst_en,
    input  logic              port_learn,
    output logic [NPORTS-1:0] mask,
    output logic              learn
);

    // Choose between the looked-up mask and the unknown-destination flood.
    always_comb begin
        if (unrec)
            mask = unrec_cpu_en ? '1 : ~CPU_MASK;
        else
            mask = lookup_mask;
    end

    assign learn = unrec && learn_dst_en && port_learn;

endmodule

// File: rtl/fpr_path_sel.sv
// Path selection: decides whether the pending frame is settled on the
// fast path or must wait for the full lookup. Full forcing wins over
// fast forcing; without forcing, a fast hit settles the frame.
module fpr_path_sel (
    input  logic force_fast,
    input  logic force_full,
    input  logic fast_hit,
    output logic use_full
);

    // Priority order: force_full, then force_fast, then the hit itself.
    always_comb begin
        if (force_full)
            use_full = 1'b1;
        else if (force_fast)
            use_full = 1'b0;
        else
            use_full = !fast_hit;
    end

endmodule

// File: rtl/fwd_policy_resolver.sv
// Forwarding decision policy resolver, top level.
// Holds one frame in a pending slot, settles it from the fast path or the
// full lookup, falls back to drop or flood when the next frame arrives
// before the full response, and registers the decision with a valid strobe.
// Assumes at most one new frame per cycle and configuration that changes
// only while no frame is pending.
module fwd_policy_resolver
    import fpr_pkg::*;
#(
    parameter int unsigned NPORTS = 8,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned LVL_W  = 6,
    parameter logic [NPORTS-1:0] CPU_MASK = 8'h01,
    localparam int unsigned NPRIO = 1 << PRIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPRIO-1:0]   cfg_prio_mask,
    input  logic               cfg_hp_cpu_en,
    input  logic               cfg_unrec_cpu_en,
    input  logic               cfg_slow_bcast,
    input  logic               cfg_learn_dst_en,
    input  logic               cfg_force_fast,
    input  logic               cfg_force_full,
    input  logic               req_valid,
    input  logic [1:0]         req_class,
    input  logic [PRIO_W-1:0]  req_prio,
    input  logic [NPORTS-1:0]  req_fast_mask,
    input  logic               req_port_learn,
    input  logic               full_valid,
    input  logic [NPORTS-1:0]  full_mask,
    input  logic               full_unrec,
    input  logic [LVL_W-1:0]   uq_level,
    output logic               dec_valid,
    output logic [NPORTS-1:0]  dec_mask,
    output logic               dec_drop,
    output logic               dec_hp,
    output logic               dec_learn,
    output logic               uq_irq
);

    localparam logic [NPORTS-1:0] FLOOD_MASK = ~CPU_MASK;

    // Pending slot
    logic               pend_v;
    ff_class_t          pend_cls;
    logic [PRIO_W-1:0]  pend_prio;
    logic [NPORTS-1:0]  pend_mask;
    logic               pend_learn;

    // Path results
    logic               fast_hit;
    logic               fast_hp;
    logic [NPORTS-1:0]  fast_mask;
    logic [NPORTS-1:0]  full_res_mask;
    logic               full_learn;
    logic               use_full;

    // Next decision
    logic               ready_fast;
    logic               ready_full;
    logic               stale;
    logic               emit;
    logic [NPORTS-1:0]  mask_n;
    logic               hp_n;
    logic               learn_n;

    fpr_fast_path #(
        .NPORTS  (NPORTS),
        .PRIO_W  (PRIO_W),
        .CPU_MASK(CPU_MASK)
    ) u_fast (
        .cls       (pend_cls),
        .prio      (pend_prio),
        .ucast_mask(pend_mask),
        .prio_mask (cfg_prio_mask),
        .hp_cpu_en (cfg_hp_cpu_en),
        .hit       (fast_hit),
        .hp        (fast_hp),
        .mask      (fast_mask)
    );

    fpr_full_path #(
        .NPORTS  (NPORTS),
        .CPU_MASK(CPU_MASK)
    ) u_full (
        .lookup_mask (full_mask),
        .unrec       (full_unrec),
        .unrec_cpu_en(cfg_unrec_cpu_en),
        .learn_dst_en(cfg_learn_dst_en),
        .port_learn  (pend_learn),
        .mask        (full_res_mask),
        .learn       (full_learn)
    );

    fpr_path_sel u_sel (
        .force_fast(cfg_force_fast),
        .force_full(cfg_force_full),
        .fast_hit  (fast_hit),
        .use_full  (use_full)
    );

    assign ready_fast = pend_v && !use_full;
    assign ready_full = pend_v && use_full && full_valid;
    assign stale      = pend_v && use_full && !full_valid && req_valid;
    assign emit       = ready_fast || ready_full || stale;

    // Form the decision that will be registered this cycle.
    always_comb begin
        mask_n  = '0;
        hp_n    = 1'b0;
        learn_n = 1'b0;
        if (ready_fast) begin
            mask_n = fast_mask;
            hp_n   = fast_hp;
        end else if (ready_full) begin
            mask_n  = full_res_mask;
            learn_n = full_learn;
        end else if (stale) begin
            mask_n = cfg_slow_bcast ? FLOOD_MASK : '0;
        end
    end

    // Track the pending frame: load on arrival, clear once decided.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_cls   <= FF_NONE;
            pend_prio  <= '0;
            pend_mask  <= '0;
            pend_learn <= 1'b0;
        end else begin
            pend_v <= req_valid || (pend_v && !emit);
            if (req_valid) begin
                pend_cls   <= ff_class_t'(req_class);
                pend_prio  <= req_prio;
                pend_mask  <= req_fast_mask;
                pend_learn <= req_port_learn;
            end
        end
    end

    // Register the decision outputs; zero when nothing is decided.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_mask  <= '0;
            dec_drop  <= 1'b0;
            dec_hp    <= 1'b0;
            dec_learn <= 1'b0;
        end else begin
            dec_valid <= emit;
            dec_mask  <= mask_n;
            dec_drop  <= emit && (mask_n == '0);
            dec_hp    <= hp_n;
            dec_learn <= learn_n;
        end
    end

    // Register the queue-not-empty level interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) uq_irq <= 1'b0;
        else        uq_irq <= (uq_level != '0);
    end

endmodule

// File: rtl/fpr_checker.sv
// Port-level properties of the policy resolver, bound to its top module.
// Assumes configuration inputs are steady around each decision.
module fpr_checker #(
    parameter int unsigned NPORTS = 8,
    parameter int unsigned LVL_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_learn_dst_en,
    input logic              cfg_force_fast,
    input logic              cfg_force_full,
    input logic [LVL_W-1:0]  uq_level,
    input logic              dec_valid,
    input logic [NPORTS-1:0] dec_mask,
    input logic              dec_drop,
    input logic              dec_hp,
    input logic              dec_learn,
    input logic              uq_irq
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (dec_mask == '0 && !dec_drop && !dec_hp && !dec_learn));

    p_hp_not_learn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hp |-> (!dec_learn && dec_valid));

    p_learn_needs_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_learn_dst_en |=> !dec_learn);

    p_forced_fast_no_learn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_force_fast && !cfg_force_full) |=> !dec_learn);

    p_irq_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (uq_level != '0) |=> uq_irq);

    p_irq_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (uq_level == '0) |=> !uq_irq);

endmodule

bind fwd_policy_resolver fpr_checker #(
    .NPORTS(NPORTS),
    .LVL_W (LVL_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_learn_dst_en(cfg_learn_dst_en),
    .cfg_force_fast  (cfg_force_fast),
    .cfg_force_full  (cfg_force_full),
    .uq_level        (uq_level),
    .dec_valid       (dec_valid),
    .dec_mask        (dec_mask),
    .dec_drop        (dec_drop),
    .dec_hp          (dec_hp),
    .dec_learn       (dec_learn),
    .uq_irq          (uq_irq)
);

// File: tb/sim_fwd_policy_resolver.sv
// Bench for the forwarding decision policy resolver: a behavioural
// reference model advanced on each rising edge, compared on each falling edge.
module sim_fwd_policy_resolver;

    localparam int NP = 8;
    localparam int PW = 3;
    localparam int LW = 6;
    localparam logic [NP-1:0] CPU = 8'h01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]    cfg_prio_mask = '0;
    logic          cfg_hp_cpu_en = 0, cfg_unrec_cpu_en = 0, cfg_slow_bcast = 0;
    logic          cfg_learn_dst_en = 0, cfg_force_fast = 0, cfg_force_full = 0;
    logic          req_valid = 0;
    logic [1:0]    req_class = '0;
    logic [PW-1:0] req_prio = '0;
    logic [NP-1:0] req_fast_mask = '0;
    logic          req_port_learn = 0;
    logic          full_valid = 0;
    logic [NP-1:0] full_mask = '0;
    logic          full_unrec = 0;
    logic [LW-1:0] uq_level = '0;
    logic          dec_valid, dec_drop, dec_hp, dec_learn, uq_irq;
    logic [NP-1:0] dec_mask;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    fwd_policy_resolver #(.NPORTS(NP), .PRIO_W(PW), .LVL_W(LW), .CPU_MASK(CPU)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_prio_mask(cfg_prio_mask), .cfg_hp_cpu_en(cfg_hp_cpu_en),
        .cfg_unrec_cpu_en(cfg_unrec_cpu_en), .cfg_slow_bcast(cfg_slow_bcast),
        .cfg_learn_dst_en(cfg_learn_dst_en), .cfg_force_fast(cfg_force_fast),
        .cfg_force_full(cfg_force_full),
        .req_valid(req_valid), .req_class(req_class), .req_prio(req_prio),
        .req_fast_mask(req_fast_mask), .req_port_learn(req_port_learn),
        .full_valid(full_valid), .full_mask(full_mask), .full_unrec(full_unrec),
        .uq_level(uq_level),
        .dec_valid(dec_valid), .dec_mask(dec_mask), .dec_drop(dec_drop),
        .dec_hp(dec_hp), .dec_learn(dec_learn), .uq_irq(uq_irq)
    );

    // Reference model state
    bit        m_wait;
    int        m_cls, m_prio, m_learn;
    bit [NP-1:0] m_fm;
    bit        e_valid, e_drop, e_hp, e_learn, e_irq;
    bit [NP-1:0] e_mask;

    always @(posedge clk) begin
        bit goes_full, decided;
        bit [NP-1:0] mk;
        bit hp, ln;
        if (!rst_n) begin
            m_wait = 0; e_valid = 0; e_mask = 0; e_drop = 0; e_hp = 0; e_learn = 0; e_irq = 0;
        end else begin
            decided = 0; mk = 0; hp = 0; ln = 0;
            if (m_wait) begin
                if (cfg_force_full)      goes_full = 1;
                else if (cfg_force_fast) goes_full = 0;
                else                     goes_full = (m_cls == 0);
                if (!goes_full) begin
                    decided = 1;
                    hp = (m_cls != 0) && cfg_prio_mask[m_prio];
                    if (m_cls == 1) mk = '1;
                    else if (m_cls == 2) mk = m_fm;
                    else if (m_cls == 3) mk = CPU;
                    if (hp && !cfg_hp_cpu_en && m_cls != 3) mk = mk & ~CPU;
                end else if (full_valid) begin
                    decided = 1;
                    if (full_unrec) begin
                        mk = cfg_unrec_cpu_en ? '1 : ~CPU;
                        ln = cfg_learn_dst_en && (m_learn != 0);
                    end else mk = full_mask;
                end else if (req_valid) begin
                    decided = 1;
                    mk = cfg_slow_bcast ? ~CPU : '0;
                end
            end
            e_valid = decided; e_mask = mk; e_hp = hp; e_learn = ln;
            e_drop = decided && (mk == 0);
            e_irq = (uq_level != 0);
            if (decided) m_wait = 0;
            if (req_valid) begin
                m_wait = 1; m_cls = req_class; m_prio = req_prio;
                m_fm = req_fast_mask; m_learn = req_port_learn;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("dec_valid", 32'(dec_valid), 32'(e_valid));
            chk("dec_mask", 32'(dec_mask), 32'(e_mask));
            chk("dec_drop", 32'(dec_drop), 32'(e_drop));
            chk("dec_hp", 32'(dec_hp), 32'(e_hp));
            chk("dec_learn", 32'(dec_learn), 32'(e_learn));
            chk("uq_irq", 32'(uq_irq), 32'(e_irq));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] c, input int p, input logic [NP-1:0] m, input bit le);
        @(negedge clk);
        req_valid = 1; req_class = c; req_prio = PW'(p); req_fast_mask = m; req_port_learn = le;
        @(negedge clk);
        req_valid = 0; req_class = 0; req_fast_mask = 0; req_port_learn = 0;
    endtask

    task automatic respond(input logic [NP-1:0] m, input bit u);
        @(negedge clk);
        full_valid = 1; full_mask = m; full_unrec = u;
        @(negedge clk);
        full_valid = 0; full_mask = 0; full_unrec = 0;
    endtask

    // Stimulus
    initial begin
        tag = "R1";
        idle(3);
        total++;
        if (dec_valid !== 0 || dec_mask !== 0 || uq_irq !== 0) begin
            bad++;
            $display("FAIL R1 reset outputs: actual=%b/%h/%b expected=0/00/0", dec_valid, dec_mask, uq_irq);
        end
        rst_n = 1;
        idle(2);

        tag = "R2"; send(2, 1, 8'h5B, 0); idle(2);
        send(1, 0, 8'h00, 0); idle(2);
        tag = "R3"; cfg_prio_mask = 8'h20; send(2, 5, 8'h30, 0); idle(2);
        send(2, 4, 8'h30, 0); idle(2);
        tag = "R4"; send(1, 5, 8'h00, 0); idle(2);
        send(2, 5, 8'h01, 0); idle(2);
        send(3, 5, 8'h00, 0); idle(2);
        cfg_hp_cpu_en = 1; idle(1); send(1, 5, 8'h00, 0); idle(2);
        cfg_hp_cpu_en = 0;
        tag = "R5"; send(0, 5, 8'h00, 0); idle(3); respond(8'h3C, 0); idle(2);
        respond(8'hAA, 0); idle(2);
        tag = "R6"; send(0, 0, 8'h00, 0); idle(1); respond(8'h00, 1); idle(2);
        cfg_unrec_cpu_en = 1; idle(1); send(0, 0, 8'h00, 0); respond(8'h00, 1); idle(2);
        cfg_unrec_cpu_en = 0;
        tag = "R7"; cfg_learn_dst_en = 1; idle(1);
        send(0, 0, 8'h00, 1); respond(8'h00, 1); idle(2);
        send(0, 0, 8'h00, 0); respond(8'h00, 1); idle(2);
        send(0, 0, 8'h00, 1); respond(8'h42, 0); idle(2);
        cfg_learn_dst_en = 0; idle(1);
        send(0, 0, 8'h00, 1); respond(8'h00, 1); idle(2);
        tag = "R8"; send(0, 0, 8'h00, 0); idle(1); send(0, 0, 8'h00, 0); idle(1);
        respond(8'h18, 0); idle(2);
        cfg_slow_bcast = 1; idle(1);
        send(0, 0, 8'h00, 0); send(2, 0, 8'h06, 0); idle(2);
        cfg_slow_bcast = 0;
        tag = "R9"; cfg_prio_mask = 8'h02; send(2, 1, 8'h01, 0); idle(2);
        cfg_prio_mask = 8'h00;
        tag = "R10"; cfg_force_fast = 1; idle(1);
        send(0, 0, 8'h00, 0); idle(1); respond(8'h77, 0); idle(2);
        send(2, 0, 8'h44, 0); idle(2);
        cfg_force_fast = 0;
        tag = "R11"; cfg_force_full = 1; idle(1);
        send(2, 0, 8'h44, 0); idle(2); respond(8'h81, 0); idle(2);
        cfg_force_fast = 1; idle(1);
        send(1, 0, 8'h00, 0); idle(1); respond(8'h09, 0); idle(2);
        cfg_force_fast = 0; cfg_force_full = 0; idle(1);
        tag = "R12"; uq_level = 6'd3; idle(3); uq_level = 6'd0; idle(3);
        uq_level = 6'd1; idle(1); uq_level = 6'd0; idle(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule